// File: doc/BRIEF.md
# RMII Receive Elasticity Buffer

This block carries a reduced-width Ethernet receive stream from the recovered receive clock into the local reference clock domain. The write side takes one 4-bit nibble per recovered-clock cycle while a write-valid flag is high. The read side hands the frame on as 2-bit symbols, one per reference-clock cycle, under its own valid flag. The two clocks are nominally in a 1:2 ratio but drift apart by up to a few hundred ppm. The buffer absorbs that drift across a maximum-length frame.

Each frame is held back at its start until the buffer holds half its pair capacity. This leaves equal headroom for a writer that runs fast and for one that runs slow. When the write-valid flag drops, the read side keeps streaming until the buffer is empty, then deasserts its valid flag and rearms for the next frame. Because every frame gets the same start latency and is drained completely, the idle gap between frames comes out with the length it went in with.

Pointers cross between the domains in Gray code through two-stage synchronisers. Each domain also keeps a sticky error flag: overflow on the write side and underflow on the read side.

Top module: `rmii_rx_elastic`

## Requirements
- R1: After a synchronous reset of both domains, rd_valid is 0, rd_data is 2'b00, and both ovf_flag and udf_flag are 0.
- R2: At a frame start, rd_valid stays low until the read side sees at least half the pair capacity stored: 2^ADDR_W two-bit entries, which is 8 entries (16 bits) with the default ADDR_W=3. The one exception is a frame that has already ended with fewer entries stored; such a frame starts draining at once.
- R3: Each accepted nibble becomes two entries. Bits [1:0] come out first, then bits [3:2]. Entries leave in write order, one per rclk cycle while rd_valid is high. rd_data is 2'b00 whenever rd_valid is low.
- R4: After wr_valid falls, rd_valid stays high without a break until every stored entry has been delivered, and then it falls. This holds for frames shorter than the start threshold too. The read pointer never passes the synchronised write pointer.
- R5: After a frame has drained, the next frame again waits for the half-capacity threshold of R2 before rd_valid rises.
- R6: A gap of G wclk cycles with wr_valid low between two frames, with G at least 9 (36 bits), appears on the read side as 2·G rclk cycles with rd_valid low, within one cycle.
- R7: With wclk offset by ±150 ppm from half the rclk rate, a 3036-nibble frame passes with every entry intact and with neither flag set.
- R8: The write and read pointers cross domains as Gray codes that change by at most one bit per clock cycle of their own domain.
- R9: A nibble presented while the buffer is full is discarded, and the write pointer does not move. ovf_flag then goes high and stays high until w_rst.
- R10: If the buffer runs empty while a frame is still being written, udf_flag goes high and stays high until r_rst. rd_valid falls, and output resumes only once the R2 threshold is met again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Recovered receive clock (write domain) |
| w_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | Nibble on wr_nib belongs to the current frame |
| wr_nib | input | 4 | Received nibble |
| rclk | input | 1 | Local reference clock (read domain) |
| r_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_valid | output | 1 | rd_data carries a frame symbol |
| rd_data | output | 2 | Two-bit output symbol, low pair of each nibble first |
| ovf_flag | output | 1 | Sticky overflow indication, write domain |
| udf_flag | output | 1 | Sticky underflow indication, read domain |

## Verification
The assertions take four things for granted about the inputs:
- Both domains are reset together and held in reset for at least two cycles of their own clock, so no pointer history from before reset reaches a $past term.
- wr_valid frames are contiguous runs of nibbles.
- The gap between frames is long enough for the previous frame to drain before new data reaches the read side.
- Full and empty conditions come only from sustained clock offset.

The stimulus holds the write clock at exactly half the read rate, or within ±150 ppm of it, except in the two tests that stretch or shrink the write period by 10 % on purpose to force overflow and underflow. Every inter-frame gap it drives is nine nibbles or longer.

// File: rtl/rxeb_pkg.sv
`timescale 1ns/1ps
package rxeb_pkg;

    localparam int DFLT_ADDR_W = 3;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        RD_WAIT = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_e;

    // one stored nibble, split into the two symbols the read side emits
    typedef struct packed {
        logic [1:0] hi;
        logic [1:0] lo;
    } nib_t;

    function automatic logic [1:0] pick_pair(nib_t n, logic upper);
        return upper ? n.hi : n.lo;
    endfunction

endpackage

// File: rtl/rxeb_sync.sv
`timescale 1ns/1ps
module rxeb_sync #(
    parameter int W      = 4,
    parameter int STAGES = rxeb_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/rxeb_store.sv
`timescale 1ns/1ps
module rxeb_store
    import rxeb_pkg::*;
#(
    parameter int ADDR_W = DFLT_ADDR_W
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [3:0]        wdata,
    input  logic [ADDR_W:0]   raddr,
    output logic [1:0]        rpair
);
    localparam int NIBS = 1 << ADDR_W;

    nib_t mem [NIBS];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= nib_t'(wdata);
    end

    // location under the read pointer is stable: its write completed before
    // the synchronised write pointer could cover it
    assign rpair = pick_pair(mem[raddr[ADDR_W:1]], raddr[0]);
endmodule

// File: rtl/rxeb_wside.sv
`timescale 1ns/1ps
module rxeb_wside
    import rxeb_pkg::*;
#(
    parameter int ADDR_W = DFLT_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W:0]   rgray_s,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              wframe,
    output logic              full,
    output logic              ovf
);
    localparam int PW   = ADDR_W + 1;
    localparam int NIBS = 1 << ADDR_W;

    logic [PW-1:0] wptr, wptr_nx, rnib, used;

    always_comb begin
        for (int i = 0; i < PW; i++) rnib[i] = ^(rgray_s >> i);
    end

    assign used    = wptr - rnib;
    assign full    = (used == PW'(NIBS));
    assign we      = wr_valid && !full;
    assign waddr   = wptr[ADDR_W-1:0];
    assign wptr_nx = wptr + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr   <= '0;
            wgray  <= '0;
            wframe <= 1'b0;
            ovf    <= 1'b0;
        end else begin
            wframe <= wr_valid;
            if (we) begin
                wptr  <= wptr_nx;
                wgray <= wptr_nx ^ (wptr_nx >> 1);
            end
            if (wr_valid && full) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/rxeb_rside.sv
`timescale 1ns/1ps
module rxeb_rside
    import rxeb_pkg::*;
#(
    parameter int ADDR_W = DFLT_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic              wframe_s,
    input  logic [1:0]        rpair,
    output logic [ADDR_W:0]   raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [ADDR_W+1:0] level,
    output logic              rd_valid,
    output logic [1:0]        rd_data,
    output logic              udf
);
    localparam int PW    = ADDR_W + 1;
    localparam int RW    = ADDR_W + 2;
    localparam int START = 1 << ADDR_W;

    rd_state_e     state;
    logic [RW-1:0] rptr, rptr_nx;
    logic [PW-1:0] wbin, rnib_nx;
    logic          eof_seen, start_ok, go;

    always_comb begin
        for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_s >> i);
    end

    assign level    = {wbin, 1'b0} - rptr;
    assign start_ok = (level >= RW'(START)) || (!wframe_s && level != '0);
    assign go       = (state == RD_RUN) ? (level != '0) : start_ok;
    assign rptr_nx  = rptr + RW'(1);
    assign rnib_nx  = rptr_nx[RW-1:1];
    assign raddr    = rptr[ADDR_W:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RD_WAIT;
            rptr     <= '0;
            rgray    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= 2'b00;
            eof_seen <= 1'b0;
            udf      <= 1'b0;
        end else begin
            rd_valid <= go;
            rd_data  <= go ? rpair : 2'b00;
            state    <= go ? RD_RUN : RD_WAIT;
            eof_seen <= go ? (eof_seen || !wframe_s) : 1'b0;
            if (go) begin
                rptr  <= rptr_nx;
                rgray <= rnib_nx ^ (rnib_nx >> 1);
            end
            if (state == RD_RUN && !go && wframe_s && !eof_seen) udf <= 1'b1;
        end
    end
endmodule

// File: rtl/rmii_rx_elastic.sv
`timescale 1ns/1ps
module rmii_rx_elastic
    import rxeb_pkg::*;
#(
    parameter int ADDR_W = DFLT_ADDR_W
) (
    input  logic       wclk,
    input  logic       w_rst,
    input  logic       wr_valid,
    input  logic [3:0] wr_nib,
    input  logic       rclk,
    input  logic       r_rst,
    output logic       rd_valid,
    output logic [1:0] rd_data,
    output logic       ovf_flag,
    output logic       udf_flag
);
    localparam int PW = ADDR_W + 1;
    localparam int RW = ADDR_W + 2;

    logic              we, w_full, w_frame, r_frame;
    logic [ADDR_W-1:0] waddr;
    logic [PW-1:0]     w_gray, w_gray_s, r_gray, r_gray_s;
    logic [ADDR_W:0]   raddr;
    logic [1:0]        rpair;
    logic [RW-1:0]     r_level;

    rxeb_wside #(.ADDR_W(ADDR_W)) u_wside (
        .clk(wclk), .rst(w_rst), .wr_valid(wr_valid), .rgray_s(r_gray_s),
        .we(we), .waddr(waddr), .wgray(w_gray), .wframe(w_frame),
        .full(w_full), .ovf(ovf_flag)
    );

    rxeb_store #(.ADDR_W(ADDR_W)) u_store (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_nib),
        .raddr(raddr), .rpair(rpair)
    );

    rxeb_sync #(.W(PW)) u_sync_r2w (
        .clk(wclk), .rst(w_rst), .d(r_gray), .q(r_gray_s)
    );

    rxeb_sync #(.W(PW + 1)) u_sync_w2r (
        .clk(rclk), .rst(r_rst), .d({w_frame, w_gray}), .q({r_frame, w_gray_s})
    );

    rxeb_rside #(.ADDR_W(ADDR_W)) u_rside (
        .clk(rclk), .rst(r_rst), .wgray_s(w_gray_s), .wframe_s(r_frame),
        .rpair(rpair), .raddr(raddr), .rgray(r_gray), .level(r_level),
        .rd_valid(rd_valid), .rd_data(rd_data), .udf(udf_flag)
    );
endmodule

// File: rtl/rmii_rx_elastic_chk.sv
`timescale 1ns/1ps
module rmii_rx_elastic_chk #(
    parameter int ADDR_W = rxeb_pkg::DFLT_ADDR_W
) (
    input logic              wclk,
    input logic              w_rst,
    input logic              rclk,
    input logic              r_rst,
    input logic              wr_valid,
    input logic              w_full,
    input logic [ADDR_W:0]   w_gray,
    input logic [ADDR_W:0]   r_gray,
    input logic [ADDR_W+1:0] r_level,
    input logic              r_frame,
    input logic              rd_valid,
    input logic              ovf_flag,
    input logic              udf_flag
);
    localparam int START = 1 << ADDR_W;

    p_wgray_onebit_r8: assert property (@(posedge wclk) disable iff (w_rst)
        $countones(w_gray ^ $past(w_gray)) <= 1);

    p_rgray_onebit_r8: assert property (@(posedge rclk) disable iff (r_rst)
        $countones(r_gray ^ $past(r_gray)) <= 1);

    p_fill_before_start_r2: assert property (@(posedge rclk) disable iff (r_rst)
        $rose(rd_valid) |-> ($past(r_level) >= START || !$past(r_frame)));

    p_no_read_past_write_r4: assert property (@(posedge rclk) disable iff (r_rst)
        (r_level == '0) |=> $stable(r_gray));

    p_full_drops_write_r9: assert property (@(posedge wclk) disable iff (w_rst)
        (w_full && wr_valid) |=> $stable(w_gray));

    p_ovf_sticky_r9: assert property (@(posedge wclk) disable iff (w_rst)
        ovf_flag |=> ovf_flag);

    p_udf_sticky_r10: assert property (@(posedge rclk) disable iff (r_rst)
        udf_flag |=> udf_flag);
endmodule

bind rmii_rx_elastic rmii_rx_elastic_chk #(.ADDR_W(ADDR_W)) u_chk (
    .wclk(wclk), .w_rst(w_rst), .rclk(rclk), .r_rst(r_rst),
    .wr_valid(wr_valid), .w_full(w_full), .w_gray(w_gray), .r_gray(r_gray),
    .r_level(r_level), .r_frame(r_frame), .rd_valid(rd_valid),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag)
);

// File: tb/rmii_rx_elastic_test.sv
`timescale 1ns/1ps
module rmii_rx_elastic_test;
    localparam int START = 8;

    logic       wclk = 1'b0, rclk = 1'b0;
    logic       w_rst = 1'b1, r_rst = 1'b1;
    logic       wr_valid = 1'b0;
    logic [3:0] wr_nib = 4'h0;
    logic       rd_valid, ovf_flag, udf_flag;
    logic [1:0] rd_data;

    real wper = 40.0;

    int checks = 0, errors = 0;
    int cyc = 0, out_cnt = 0, bad = 0, rises = 0, idle_nz = 0;
    int low_run = 0, rise_gap = 0, min_depth = 1000;
    bit mon_check = 1'b1, prev_v = 1'b0;
    logic [1:0] q[$];

    rmii_rx_elastic uut (
        .wclk(wclk), .w_rst(w_rst), .wr_valid(wr_valid), .wr_nib(wr_nib),
        .rclk(rclk), .r_rst(r_rst), .rd_valid(rd_valid), .rd_data(rd_data),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    initial forever #10 rclk = ~rclk;
    initial forever #(wper / 2.0) wclk = ~wclk;

    // read-side monitor, sampling away from the active edge
    always @(negedge rclk) begin
        cyc++;
        if (cyc == 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (rd_valid) begin
            if (!prev_v) begin
                rises++;
                rise_gap = low_run;
                if (q.size() < min_depth) min_depth = q.size();
            end
            out_cnt++;
            if (mon_check) begin
                if (q.size() == 0) bad++;
                else if (q.pop_front() != rd_data) bad++;
            end
            low_run = 0;
        end else begin
            low_run++;
            if (rd_data != 2'b00) idle_nz++;
        end
        prev_v = rd_valid;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        out_cnt = 0; bad = 0; rises = 0; idle_nz = 0; min_depth = 1000;
    endtask

    task automatic do_reset(input real per);
        wper = per;
        wr_valid = 1'b0;
        w_rst = 1'b1; r_rst = 1'b1;
        repeat (4) @(negedge wclk);
        w_rst = 1'b0; r_rst = 1'b0;
        repeat (4) @(negedge rclk);
        q.delete();
        mon_check = 1'b1;
        clear_stats();
    endtask

    task automatic send_frame(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            logic [3:0] v;
            @(negedge wclk);
            v = 4'((i * 7 + seed) ^ (i >> 2));
            wr_valid = 1'b1;
            wr_nib   = v;
            q.push_back(v[1:0]);
            q.push_back(v[3:2]);
        end
    endtask

    task automatic idle(input int g);
        @(negedge wclk);
        wr_valid = 1'b0;
        repeat (g - 1) @(negedge wclk);
    endtask

    task automatic drain();
        repeat (80) @(negedge rclk);
    endtask

    task automatic t_reset();
        do_reset(40.0);
        check(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
        check(rd_data == 2'b00, "R1 rd_data", int'(rd_data), 0);
        check(ovf_flag == 1'b0, "R1 ovf_flag", int'(ovf_flag), 0);
        check(udf_flag == 1'b0, "R1 udf_flag", int'(udf_flag), 0);
    endtask

    task automatic t_basic();
        do_reset(40.0);
        send_frame(20, 3); idle(1); drain();
        check(bad == 0, "R3 data order", bad, 0);
        check(idle_nz == 0, "R3 idle data zero", idle_nz, 0);
        check(out_cnt == 40, "R4 all entries out", out_cnt, 40);
        check(rises == 1, "R4 contiguous output", rises, 1);
        check(min_depth >= START, "R2 fill before start", min_depth, START);
    endtask

    task automatic t_short();
        do_reset(40.0);
        send_frame(2, 9); idle(1); drain();
        check(out_cnt == 4, "R4 short frame drained", out_cnt, 4);
        check(bad == 0, "R3 short frame data", bad, 0);
    endtask

    task automatic t_two_frames();
        do_reset(40.0);
        send_frame(30, 1); idle(9); send_frame(30, 5); idle(1); drain();
        check(rises == 2, "R5 two separate bursts", rises, 2);
        check(min_depth >= START, "R5 rearmed threshold", min_depth, START);
        check(rise_gap >= 17 && rise_gap <= 19, "R6 gap preserved", rise_gap, 18);
        check(out_cnt == 120 && bad == 0, "R3 two-frame data", bad, 0);
    endtask

    task automatic t_drift(input real per, input string tag);
        do_reset(per);
        send_frame(3036, 11); idle(1); drain();
        check(out_cnt == 6072, {"R7 count ", tag}, out_cnt, 6072);
        check(bad == 0, {"R7 data ", tag}, bad, 0);
        check(ovf_flag == 1'b0, {"R7 no overflow ", tag}, int'(ovf_flag), 0);
        check(udf_flag == 1'b0, {"R7 no underflow ", tag}, int'(udf_flag), 0);
    endtask

    task automatic t_overflow();
        do_reset(36.0);
        mon_check = 1'b0;
        send_frame(120, 2); idle(1); drain();
        check(ovf_flag == 1'b1, "R9 overflow flagged", int'(ovf_flag), 1);
        check(out_cnt < 240, "R9 writes dropped", out_cnt, 239);
        check(udf_flag == 1'b0, "R10 no underflow on fast writer", int'(udf_flag), 0);
        wper = 40.0;
        q.delete(); mon_check = 1'b1; clear_stats();
        send_frame(10, 4); idle(1); drain();
        check(ovf_flag == 1'b1, "R9 overflow sticky", int'(ovf_flag), 1);
        check(out_cnt == 20 && bad == 0, "R9 recovery frame", bad, 0);
        do_reset(40.0);
        check(ovf_flag == 1'b0, "R9 cleared by reset", int'(ovf_flag), 0);
    endtask

    task automatic t_underflow();
        do_reset(44.0);
        send_frame(120, 6); idle(1); drain();
        check(udf_flag == 1'b1, "R10 underflow flagged", int'(udf_flag), 1);
        check(rises > 1, "R10 valid dropped and rearmed", rises, 2);
        check(out_cnt == 240 && bad == 0, "R10 data intact", bad, 0);
        check(ovf_flag == 1'b0, "R9 no overflow on slow writer", int'(ovf_flag), 0);
        wper = 40.0;
        send_frame(10, 8); idle(1); drain();
        check(udf_flag == 1'b1, "R10 underflow sticky", int'(udf_flag), 1);
        do_reset(40.0);
        check(udf_flag == 1'b0, "R10 cleared by reset", int'(udf_flag), 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_short();
        t_two_frames();
        t_drift(40.006, "slow");
        t_drift(39.994, "fast");
        t_overflow();
        t_underflow();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule